// File: doc/BRIEF.md
# USB Packet Line Encoder

This block turns one USB packet, handed over as a stream of bytes, into the levels on a differential line pair at full or low speed. A source offers bytes on a valid/ready handshake. It marks the final byte of the packet with a last flag. With the first byte it also says whether a 16-bit checksum should follow the payload. The encoder then sends the following, one symbol per bit-time strobe:

- a synchronisation pattern;
- every byte, least significant bit first;
- the checksum, when requested;
- a zero after every six consecutive ones;
- the end-of-packet signalling.

All of these are carried on the line in NRZI form. After the end-of-packet signalling the encoder releases the line.

The bit rate comes from a one-cycle strobe supplied by the surrounding logic. Every symbol lasts exactly one strobe period, whether it is a synchronisation bit, a payload bit, an inserted stuff bit or an end-of-packet state. A single-entry holding register sits between the handshake and the serializer. The source therefore has a full byte time to offer the next byte. If the register is empty when a byte is needed, the packet ends there.

Top module: `usbtx_serializer`

## Requirements
- R1: After reset, and whenever no packet is in flight, `oe` is 0, `dp` is 1 and `dm` is 0 (the released idle J state), and `in_ready` is 1.
- R2: `dp`, `dm` and `oe` change only in the clock cycle that follows a cycle with `bit_stb` high, so each line symbol lasts exactly one strobe period.
- R3: A packet starts with eight symbols whose pre-coding bits are seven 0s and then one 1. Starting from J, the line therefore shows K J K J K J K K (`dp` = 0,1,0,1,0,1,0,0).
- R4: The bytes follow the synchronisation pattern in the order they were accepted, each sent bit 0 first. The first byte is the packet identifier.
- R5: NRZI coding: a pre-coding 1 keeps the previous line level and a 0 inverts it. J is `dp`=1,`dm`=0 and K is `dp`=0,`dm`=1.
- R6: Once six consecutive 1s have been sent, an extra 0 is inserted before the next bit. This holds for payload and checksum bits, and also directly after the final bit and before the end-of-packet signalling.
- R7: When `in_crc` was 1 with the first byte, 16 checksum bits follow the last byte. The checksum register is preset to all ones, uses generator x^16+x^15+x^2+1 and covers every byte except the identifier. It is sent inverted, least significant bit first. A packet holding only the identifier therefore carries sixteen 0s.
- R8: The packet ends with two symbols with both `dp` and `dm` low and `oe` high, then one J symbol with `oe` high, then the line is released (`oe` low, J).
- R9: `in_ready` is 0 during an inserted stuff bit, during checksum bits, during the end-of-packet symbols, and from acceptance of the last byte until the line is released.
- R10: `in_crc` is sampled only with the first byte of a packet. Its value on later bytes has no effect on whether a checksum is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | One-cycle pulse marking each bit time |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Offered byte is the final one of the packet |
| in_crc | input | 1 | With the first byte: append the checksum |
| in_ready | output | 1 | Byte accepted on a cycle where it is high together with `in_valid` |
| dp | output | 1 | Positive line level |
| dm | output | 1 | Negative line level |
| oe | output | 1 | Line driver enable |

## Verification
A wrong stuffing run counter or NRZI level has a lasting effect at the ports: every following symbol of the packet shows the inverted level or is shifted by one. A scoreboard that compares each symbol with a bench-built line image therefore catches the fault within one strobe period of its cause. A checksum register with a wrong preset or polynomial shows nothing until the trailing sixteen symbols. Those are compared one by one, as are the two low-low symbols and the release that follow. Handshake faults show up as `in_ready` being high on a symbol that must be quiet, or as a missing or duplicated byte, which throws off every later symbol of the stream.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  localparam int CRC_W     = 16;
  localparam int CRC_IDX_W = $clog2(CRC_W);
  // generator x^16+x^15+x^2+1 in bit-reversed form for LSB-first feeding
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'hA001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_DATA, ST_CRC, ST_EOP
  } fr_state_t;

  typedef enum logic [2:0] {
    SYM_NONE, SYM_BIT, SYM_SE0, SYM_J, SYM_REL
  } sym_kind_t;

  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc16_step = (c >> 1) ^ (fb ? CRC_POLY_REV : '0);
  endfunction

  function automatic logic nrzi_next(input logic level, input logic b);
    nrzi_next = b ? level : ~level;
  endfunction

endpackage

// File: rtl/usbtx_byte_stage.sv
module usbtx_byte_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_crc,
  output logic              in_ready,
  input  logic              take,
  input  logic              hold,
  input  logic              pkt_done,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_last,
  output logic              buf_first,
  output logic              buf_crc
);

  logic seen_last;
  logic in_pkt;
  logic accept;

  assign in_ready = !buf_full && !seen_last && !hold;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full  <= 1'b0;
      buf_data  <= '0;
      buf_last  <= 1'b0;
      buf_first <= 1'b0;
      buf_crc   <= 1'b0;
      seen_last <= 1'b0;
      in_pkt    <= 1'b0;
    end else begin
      if (accept) begin
        buf_full  <= 1'b1;
        buf_data  <= in_data;
        buf_last  <= in_last;
        buf_first <= !in_pkt;
        buf_crc   <= in_crc;
        in_pkt    <= !in_last;
        if (in_last) seen_last <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
      if (pkt_done) begin
        seen_last <= 1'b0;
        in_pkt    <= 1'b0;
      end
    end
  end

  // R4
  take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> buf_full);

endmodule

// File: rtl/usbtx_framer.sv
module usbtx_framer
  import usbtx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int SYNC_LEN  = 8,
  parameter int EOP_SE0   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_last,
  input  logic              buf_first,
  input  logic              buf_crc,
  output logic              take,
  output logic              hold,
  output logic              pkt_done,
  output sym_kind_t         sym_kind,
  output logic              sym_bit
);

  localparam int CNT_W = $clog2(CRC_W + SYNC_LEN + DATA_W + EOP_SE0 + 2);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CRC_END  = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] EOP_J    = CNT_W'(EOP_SE0);
  localparam logic [CNT_W-1:0] EOP_REL  = CNT_W'(EOP_SE0 + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(STUFF_RUN);

  fr_state_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              cur_last, cur_pid, crc_on, stuffed_q;
  logic [CRC_W-1:0]  crc;
  logic [RUN_W-1:0]  ones;

  // named internal events
  logic stuff_now, starting, raw_bit, byte_end, more_bytes;

  assign stuff_now  = (st != ST_IDLE) && (ones == RUN_MAX);
  assign starting   = (st == ST_IDLE) && buf_full;
  assign byte_end   = (st == ST_DATA) && (cnt == BYTE_END);
  assign more_bytes = !cur_last && buf_full;

  always_comb begin
    unique case (st)
      ST_SYNC: raw_bit = (cnt == SYNC_END);
      ST_DATA: raw_bit = shreg[0];
      ST_CRC:  raw_bit = ~crc[cnt[CRC_IDX_W-1:0]];
      default: raw_bit = 1'b0;
    endcase
  end

  always_comb begin
    sym_bit = 1'b0;
    if (stuff_now) begin
      sym_kind = SYM_BIT;
    end else begin
      unique case (st)
        ST_IDLE: sym_kind = starting ? SYM_BIT : SYM_NONE;
        ST_SYNC, ST_DATA, ST_CRC: begin
          sym_kind = SYM_BIT;
          sym_bit  = raw_bit;
        end
        ST_EOP: begin
          if (cnt < EOP_J)       sym_kind = SYM_SE0;
          else if (cnt == EOP_J) sym_kind = SYM_J;
          else                   sym_kind = SYM_REL;
        end
        default: sym_kind = SYM_NONE;
      endcase
    end
  end

  assign take = bit_stb && !stuff_now &&
                (((st == ST_SYNC) && (cnt == SYNC_END)) || (byte_end && more_bytes));
  assign hold = (st == ST_CRC) || (st == ST_EOP) || stuffed_q;
  assign pkt_done = bit_stb && !stuff_now && (st == ST_EOP) && (cnt == EOP_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      cur_last  <= 1'b0;
      cur_pid   <= 1'b0;
      crc_on    <= 1'b0;
      stuffed_q <= 1'b0;
      crc       <= '1;
      ones      <= '0;
    end else if (bit_stb) begin
      if (stuff_now) begin
        ones      <= '0;
        stuffed_q <= 1'b1;
      end else begin
        stuffed_q <= 1'b0;
        if (st == ST_EOP)                      ones <= '0;
        else if (sym_kind == SYM_BIT && raw_bit) ones <= ones + 1'b1;
        else                                   ones <= '0;
        unique case (st)
          ST_IDLE: if (starting) begin
            st     <= ST_SYNC;
            cnt    <= CNT_W'(1);
            crc    <= '1;
            crc_on <= buf_crc;
          end
          ST_SYNC: if (cnt == SYNC_END) begin
            st       <= ST_DATA;
            cnt      <= '0;
            shreg    <= buf_data;
            cur_last <= buf_last;
            cur_pid  <= buf_first;
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (crc_on && !cur_pid) crc <= crc16_step(crc, shreg[0]);
            shreg <= shreg >> 1;
            if (byte_end) begin
              cnt <= '0;
              if (more_bytes) begin
                shreg    <= buf_data;
                cur_last <= buf_last;
                cur_pid  <= buf_first;
              end else begin
                st <= crc_on ? ST_CRC : ST_EOP;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_CRC: if (cnt == CRC_END) begin
            st  <= ST_EOP;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          ST_EOP: if (cnt == EOP_REL) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R6
  stuff_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stuffed_q |-> !stuff_now);

  // R7
  crc_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CRC) |-> crc_on);

endmodule

// File: rtl/usbtx_line_drv.sv
module usbtx_line_drv
  import usbtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_stb,
  input  sym_kind_t sym_kind,
  input  logic      sym_bit,
  output logic      dp,
  output logic      dm,
  output logic      oe
);

  logic level;
  logic level_nx;

  assign level_nx = nrzi_next(level, sym_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b1;
      dp    <= 1'b1;
      dm    <= 1'b0;
      oe    <= 1'b0;
    end else if (bit_stb) begin
      unique case (sym_kind)
        SYM_BIT: begin
          level <= level_nx;
          dp    <= level_nx;
          dm    <= ~level_nx;
          oe    <= 1'b1;
        end
        SYM_SE0: begin
          dp <= 1'b0;
          dm <= 1'b0;
          oe <= 1'b1;
        end
        SYM_J: begin
          level <= 1'b1;
          dp    <= 1'b1;
          dm    <= 1'b0;
          oe    <= 1'b1;
        end
        SYM_REL: begin
          level <= 1'b1;
          dp    <= 1'b1;
          dm    <= 1'b0;
          oe    <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_stb) |-> $stable({dp, dm, oe}));

  // R1
  release_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (dp && !dm));

endmodule

// File: rtl/usbtx_serializer.sv
module usbtx_serializer
  import usbtx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int SYNC_LEN  = 8,
  parameter int EOP_SE0   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_crc,
  output logic              in_ready,
  output logic              dp,
  output logic              dm,
  output logic              oe
);

  logic              take, hold, pkt_done;
  logic              buf_full, buf_last, buf_first, buf_crc;
  logic [DATA_W-1:0] buf_data;
  sym_kind_t         sym_kind;
  logic              sym_bit;

  usbtx_byte_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_crc(in_crc),
    .in_ready(in_ready),
    .take(take), .hold(hold), .pkt_done(pkt_done),
    .buf_full(buf_full), .buf_data(buf_data), .buf_last(buf_last),
    .buf_first(buf_first), .buf_crc(buf_crc)
  );

  usbtx_framer #(
    .DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN), .SYNC_LEN(SYNC_LEN), .EOP_SE0(EOP_SE0)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .buf_full(buf_full), .buf_data(buf_data), .buf_last(buf_last),
    .buf_first(buf_first), .buf_crc(buf_crc),
    .take(take), .hold(hold), .pkt_done(pkt_done),
    .sym_kind(sym_kind), .sym_bit(sym_bit)
  );

  usbtx_line_drv u_line (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .sym_kind(sym_kind), .sym_bit(sym_bit),
    .dp(dp), .dm(dm), .oe(oe)
  );

  // R9
  se0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !dp && !dm) |-> !in_ready);

endmodule

// File: tb/sim_usbtx_serializer.sv
module sim_usbtx_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;
  localparam logic [3:0] TAG_R3_SYNC = 4'd3;
  localparam logic [3:0] TAG_R4_DATA = 4'd4;
  localparam logic [3:0] TAG_R6_STUF = 4'd6;
  localparam logic [3:0] TAG_R7_CRC  = 4'd7;
  localparam logic [3:0] TAG_R8_EOP  = 4'd8;

  typedef struct packed {
    logic       quiet;
    logic [2:0] line;   // {oe, dp, dm}
    logic [3:0] req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_last = 1'b0;
  logic in_crc = 1'b0;
  logic in_ready, dp, dm, oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  exp_t exp_q[$];
  logic [7:0] tx_bytes[16];
  logic m_lvl;
  int   m_run;

  usbtx_serializer u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_crc(in_crc),
    .in_ready(in_ready), .dp(dp), .dm(dm), .oe(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // expected line image: pre-coding bit, NRZI (R5), stuffing (R6)
  task automatic emit_raw(input logic b, input logic [3:0] tag);
    m_lvl = b ? m_lvl : ~m_lvl;
    exp_q.push_back(exp_t'{(tag == TAG_R7_CRC), {1'b1, m_lvl, ~m_lvl}, tag});
    m_run = b ? m_run + 1 : 0;
    if (m_run == 6) begin
      m_lvl = ~m_lvl;
      exp_q.push_back(exp_t'{1'b1, {1'b1, m_lvl, ~m_lvl}, TAG_R6_STUF});
      m_run = 0;
    end
  endtask

  task automatic push_expected(input int n, input logic with_crc);
    logic [15:0] c;
    logic fb;
    m_lvl = 1'b1;
    m_run = 0;
    c = 16'hFFFF;
    for (int k = 0; k < 8; k++) emit_raw(k == 7, TAG_R3_SYNC);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        emit_raw(tx_bytes[i][k], TAG_R4_DATA);
        if (i > 0) begin
          fb = c[15] ^ tx_bytes[i][k];
          c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
      end
    end
    if (with_crc)
      for (int k = 15; k >= 0; k--) emit_raw(~c[k], TAG_R7_CRC);
    exp_q.push_back(exp_t'{1'b1, 3'b100, TAG_R8_EOP});
    exp_q.push_back(exp_t'{1'b1, 3'b100, TAG_R8_EOP});
    exp_q.push_back(exp_t'{1'b1, 3'b110, TAG_R8_EOP});
    exp_q.push_back(exp_t'{1'b0, 3'b010, TAG_R8_EOP});
  endtask

  // driver: queue expectations, then hand the bytes over
  task automatic send_pkt(input int n, input logic crc_first, input logic crc_later);
    push_expected(n, crc_first);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = tx_bytes[i];
      in_last  = (i == n - 1);
      in_crc   = (i == 0) ? crc_first : crc_later;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_crc   = 1'b0;
  endtask

  // strobe generator and monitor, both away from the active edge
  int   stb_cnt = 0;
  logic stb_was;
  logic mon_active = 1'b0;
  logic [2:0] last_line = 3'b010;
  exp_t e;

  always @(negedge clk) begin
    stb_was = bit_stb;
    stb_cnt = (stb_cnt + 1) % STB_DIV;
    bit_stb = (stb_cnt == 0);
    if (rst_n) begin
      if (stb_was) begin
        if (!mon_active && !oe) begin
          n_chk++;
          if ({oe, dp, dm} != 3'b010) begin
            n_bad++;
            $display("FAIL R1 idle line: got=%b expected=010", {oe, dp, dm});
          end
        end else begin
          mon_active = 1'b1;
          n_chk++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4 unexpected symbol: got=%b expected=none", {oe, dp, dm});
          end else begin
            e = exp_q.pop_front();
            if ({oe, dp, dm} != e.line) begin
              n_bad++;
              $display("FAIL R%0d (line coding R5): got=%b expected=%b", e.req, {oe, dp, dm}, e.line);
            end
            if (e.quiet) begin
              n_chk++;
              if (in_ready) begin
                n_bad++;
                $display("FAIL R9 ready during quiet symbol: got=1 expected=0");
              end
            end
            if (e.line == 3'b010) mon_active = 1'b0;
          end
        end
        last_line = {oe, dp, dm};
      end else begin
        n_chk++;
        if ({oe, dp, dm} != last_line) begin
          n_bad++;
          $display("FAIL R2 change between strobes: got=%b expected=%b", {oe, dp, dm}, last_line);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if ({oe, dp, dm, in_ready} != 4'b0101) begin
      n_bad++;
      $display("FAIL R1 reset state: got=%b expected=0101", {oe, dp, dm, in_ready});
    end

    // single identifier byte, no checksum (R3, R4, R8)
    tx_bytes[0] = 8'hD2;
    send_pkt(1, 1'b0, 1'b0);

    // long runs of ones force stuffing (R6)
    tx_bytes[0] = 8'h69; tx_bytes[1] = 8'hFF; tx_bytes[2] = 8'hFF;
    send_pkt(3, 1'b0, 1'b0);

    // payload with checksum; later in_crc low has no effect (R7, R10)
    tx_bytes[0] = 8'hC3; tx_bytes[1] = 8'h00; tx_bytes[2] = 8'h01;
    tx_bytes[3] = 8'hFF; tx_bytes[4] = 8'h7E; tx_bytes[5] = 8'h80;
    send_pkt(6, 1'b1, 1'b0);

    // identifier only with checksum: sixteen zeros (R7)
    tx_bytes[0] = 8'h4B;
    send_pkt(1, 1'b1, 1'b1);

    // six trailing ones: stuff bit before end of packet (R6)
    tx_bytes[0] = 8'hFC;
    send_pkt(1, 1'b0, 1'b0);

    // in_crc high only on later bytes: no checksum (R10), back to back
    tx_bytes[0] = 8'h5A; tx_bytes[1] = 8'h3C;
    send_pkt(2, 1'b0, 1'b1);

    // checksum over ones-heavy payload (R6, R7)
    tx_bytes[0] = 8'hC3; tx_bytes[1] = 8'hFF; tx_bytes[2] = 8'hFE;
    send_pkt(3, 1'b1, 1'b1);

    while (exp_q.size() != 0 || mon_active) @(negedge clk);
    repeat (3 * STB_DIV) @(negedge clk);
    // R9 / R1: ready and idle after the last packet
    n_chk++;
    if ({oe, dp, dm, in_ready} != 4'b0101) begin
      n_bad++;
      $display("FAIL R1 final idle: got=%b expected=0101", {oe, dp, dm, in_ready});
    end
    // R8: every expected symbol was produced
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 symbols left: got=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule